// File: doc/BRIEF.md
# Parallel Capture Sampler and Packer

This block takes in words from an external parallel data bus, one candidate per rising edge of its clock, which is the pixel clock. Two data-enable inputs decide whether an edge yields a candidate. A keep filter can then drop every other candidate. Each kept sample is cut to the configured input width. When the width is wider than 8 bits, the sample can optionally be widened to 16 bits. The kept samples are then packed, one, two or four at a time, into a 32-bit holding word.

When a word fills, it is loaded into the output register, a ready flag is raised and a one-cycle valid pulse is given. A read strobe clears the ready flag. If a word completes while the previous one is still unread, the new word replaces it and an overrun flag is raised. All configuration arrives as static inputs. A chosen falling edge of a data enable restarts the packing position and the keep phase, so that capture lines up again after a glitch.

Top module: `pcap_packer`

## Requirements
- R1: The width code `cfg_isize` selects the input width: 0 gives 8 bits, 1 gives 10, 2 gives 12 and 3 gives 14. Codes 4 to 7 act as 8 bits. Input bits above the selected width are ignored.
- R2: With `cfg_always`=0, an edge is a candidate only when `cfg_en`, `den_a` and `den_b` are all high at that edge.
- R3: With `cfg_always`=1 and `cfg_en`=1, every edge is a candidate, whatever the data enables are.
- R4: With `cfg_half`=1, candidates are numbered from 0, starting at the first candidate after reset, enable or a restart. `cfg_first`=0 keeps the even-numbered candidates and `cfg_first`=1 keeps the odd ones. This works the same with either setting of `cfg_always`. With `cfg_half`=0, every candidate is kept.
- R5: The pack code `cfg_pack` sets the samples per word: 0 gives 1, 1 gives 2 and 2 gives 4. The first sample goes in the least significant lane. A lane is 8 bits wide at 8-bit width and 16 bits wide otherwise. Unused upper bits of the word are zero.
- R6: Pack code 3, and pack code 2 at any width other than 8 bits, pack one sample per word.
- R7: At a width other than 8 bits, `cfg_scale`=1 places the W-bit sample in bits 15 down to 16-W of its lane, with zeros below. `cfg_scale`=0 zero-extends the sample. At 8-bit width, the scale setting has no effect.
- R8: `cfg_clr_sel` chooses the restart source: 0 gives none, 1 gives a falling edge of `den_a`, 2 gives a falling edge of `den_b`, and 3 gives a falling edge of either. A falling edge is high at the previous clock edge and low at this one. A selected edge drops any partly packed samples and resets the keep phase. A candidate on that same edge becomes candidate 0 in lane 0.
- R9: While `cfg_en`=0, no sample is captured and no word completes. Packing and the keep phase start over when the block is enabled again.
- R10: On the edge that completes a word, `out_word` takes the word. `out_valid` is high for exactly the following cycle and `out_ready` is set. `rd_strobe` on an edge that completes no word clears `out_ready`. After reset, all outputs are zero.
- R11: A word that completes while `out_ready` is set and `rd_strobe` is low sets `out_overrun`, and the new word replaces the old one. `rd_strobe` clears `out_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; each rising edge is a potential sample |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_data | input | 14 | Parallel input data bus |
| den_a | input | 1 | First data enable |
| den_b | input | 1 | Second data enable |
| cfg_en | input | 1 | Capture enable |
| cfg_isize | input | 3 | Input width code |
| cfg_half | input | 1 | Keep every other candidate |
| cfg_first | input | 1 | Kept phase when halving (0 even, 1 odd) |
| cfg_always | input | 1 | Ignore data enables |
| cfg_scale | input | 1 | Left-justify wide samples to 16 bits |
| cfg_pack | input | 2 | Samples per word code |
| cfg_clr_sel | input | 2 | Restart source select |
| rd_strobe | input | 1 | Takes the held word |
| out_word | output | 32 | Packed holding word |
| out_ready | output | 1 | Unread word present |
| out_valid | output | 1 | One-cycle pulse on word completion |
| out_overrun | output | 1 | Unread word was replaced |

## Verification
A wrong keep phase shows at the ports as soon as the next word completes. That word holds neighbouring samples instead of alternate ones, and the mismatch appears on the first valid pulse after the error. A stuck or stale packing position shows as samples in the wrong lanes, or as a valid pulse too early or too late, again within one word. A missed restart shows in the first word after the selected falling edge, because that word then still contains samples from before the edge. Flag mistakes show one cycle after the completing or reading edge.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

  typedef enum logic [1:0] {
    CLR_NONE = 2'd0,
    CLR_A    = 2'd1,
    CLR_B    = 2'd2,
    CLR_ANY  = 2'd3
  } clr_sel_e;

  // Input width in bits for a width code; unknown codes act as 8 bits.
  function automatic logic [4:0] width_of(input logic [2:0] code);
    case (code)
      3'd1:    width_of = 5'd10;
      3'd2:    width_of = 5'd12;
      3'd3:    width_of = 5'd14;
      default: width_of = 5'd8;
    endcase
  endfunction

  // Samples per word; four only at 8-bit width, reserved codes pack one.
  function automatic logic [2:0] count_of(input logic [1:0] code, input logic narrow);
    case (code)
      2'd1:    count_of = 3'd2;
      2'd2:    count_of = narrow ? 3'd4 : 3'd1;
      default: count_of = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/pcap_qualify.sv
module pcap_qualify
  import pcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       den_a,
  input  logic       den_b,
  input  logic       always_on,
  input  logic       half,
  input  logic       first,
  input  logic [1:0] clr_sel,
  output logic       keep,
  output logic       restart
);

  logic den_a_q, den_b_q, phase_q;
  logic fall_a, fall_b, clr, cand, phase_eff, phase_d, phase_we;

  always_comb begin
    fall_a = den_a_q & ~den_a;
    fall_b = den_b_q & ~den_b;
    case (clr_sel_e'(clr_sel))
      CLR_A:   clr = fall_a;
      CLR_B:   clr = fall_b;
      CLR_ANY: clr = fall_a | fall_b;
      default: clr = 1'b0;
    endcase
    restart   = clr | ~en;
    cand      = en & (always_on | (den_a & den_b));
    phase_eff = restart ? 1'b0 : phase_q;
    keep      = cand & (~half | (phase_eff == first));
    phase_d   = cand ? ~phase_eff : phase_eff;
    phase_we  = cand | restart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      den_a_q <= 1'b0;
      den_b_q <= 1'b0;
    end else begin
      den_a_q <= den_a;
      den_b_q <= den_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= 1'b0;
    else if (phase_we) phase_q <= phase_d;
  end

  // A restart with no candidate leaves the phase at index 0.
  assert_restart_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !cand) |=> (phase_q == 1'b0));

  // Two kept candidates in a row are impossible while halving.
  assert_half_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (half && keep && !restart) |=> !(keep && !restart && $stable(half) && half));

endmodule

// File: rtl/pcap_format.sv
module pcap_format
  import pcap_pkg::*;
#(
  parameter int DW   = 14,
  parameter int LANE = 16
) (
  input  logic [DW-1:0]   data,
  input  logic [2:0]      isize,
  input  logic            scale,
  output logic [LANE-1:0] sample,
  output logic            narrow
);

  localparam int PADW = LANE - DW;

  logic [4:0]      width;
  logic [4:0]      shamt;
  logic [31:0]     mask32;
  logic [LANE-1:0] masked;

  always_comb begin
    width  = width_of(isize);
    narrow = (width == 5'd8);
    mask32 = (32'h1 << width) - 32'h1;
    masked = {{PADW{1'b0}}, data} & mask32[LANE-1:0];
    shamt  = 5'(LANE) - width;
    if (!narrow && scale) sample = masked << shamt;
    else                  sample = masked;
  end

endmodule

// File: rtl/pcap_pack.sv
module pcap_pack
  import pcap_pkg::*;
#(
  parameter int LANE = 16,
  parameter int OW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            keep,
  input  logic            restart,
  input  logic [LANE-1:0] sample,
  input  logic            narrow,
  input  logic [1:0]      pack_code,
  input  logic            rd,
  output logic [OW-1:0]   word,
  output logic            ready,
  output logic            valid,
  output logic            overrun
);

  logic [1:0]    pos_q, pos_eff, pos_d;
  logic [OW-1:0] acc_q, acc_d, base, placed, word_d;
  logic [2:0]    cnt;
  logic          done, pos_we, ready_d, ovr_d;

  always_comb begin
    cnt     = count_of(pack_code, narrow);
    pos_eff = restart ? 2'd0 : pos_q;
    base    = (pos_eff == 2'd0) ? '0 : acc_q;
    if (narrow) placed = {{(OW-8){1'b0}}, sample[7:0]} << {pos_eff, 3'b000};
    else        placed = {{(OW-LANE){1'b0}}, sample} << {pos_eff, 4'b0000};
    acc_d   = base | placed;
    done    = keep & (({1'b0, pos_eff} + 3'd1) >= cnt);
    pos_d   = keep ? (done ? 2'd0 : pos_eff + 2'd1) : pos_eff;
    pos_we  = keep | restart;
    word_d  = done ? acc_d : word;
    ready_d = done | (ready & ~rd);
    ovr_d   = (done & ready & ~rd) | (overrun & ~rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= 2'd0;
    end else if (pos_we) begin
      pos_q <= pos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (keep) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      ready   <= 1'b0;
      valid   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      word    <= word_d;
      ready   <= ready_d;
      valid   <= done;
      overrun <= ovr_d;
    end
  end

  assert_valid_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ready);

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !done) |=> !ready);

  assert_overrun_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> (valid && $past(ready) && !$past(rd)));

endmodule

// File: rtl/pcap_packer.sv
module pcap_packer
  import pcap_pkg::*;
#(
  parameter int DW   = 14,
  parameter int LANE = 16,
  parameter int OW   = 2 * LANE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pix_data,
  input  logic          den_a,
  input  logic          den_b,
  input  logic          cfg_en,
  input  logic [2:0]    cfg_isize,
  input  logic          cfg_half,
  input  logic          cfg_first,
  input  logic          cfg_always,
  input  logic          cfg_scale,
  input  logic [1:0]    cfg_pack,
  input  logic [1:0]    cfg_clr_sel,
  input  logic          rd_strobe,
  output logic [OW-1:0] out_word,
  output logic          out_ready,
  output logic          out_valid,
  output logic          out_overrun
);

  logic            keep, restart, narrow;
  logic [LANE-1:0] sample;

  pcap_qualify u_qualify (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .den_a     (den_a),
    .den_b     (den_b),
    .always_on (cfg_always),
    .half      (cfg_half),
    .first     (cfg_first),
    .clr_sel   (cfg_clr_sel),
    .keep      (keep),
    .restart   (restart)
  );

  pcap_format #(.DW(DW), .LANE(LANE)) u_format (
    .data   (pix_data),
    .isize  (cfg_isize),
    .scale  (cfg_scale),
    .sample (sample),
    .narrow (narrow)
  );

  pcap_pack #(.LANE(LANE), .OW(OW)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .keep      (keep),
    .restart   (restart),
    .sample    (sample),
    .narrow    (narrow),
    .pack_code (cfg_pack),
    .rd        (rd_strobe),
    .word      (out_word),
    .ready     (out_ready),
    .valid     (out_valid),
    .overrun   (out_overrun)
  );

  assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !out_valid);

endmodule

// File: tb/pcap_packer_test.sv
module pcap_packer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] pix_data = '0;
  logic        den_a = 1'b0, den_b = 1'b0;
  logic        cfg_en = 1'b0, cfg_half = 1'b0, cfg_first = 1'b0;
  logic        cfg_always = 1'b0, cfg_scale = 1'b0, rd_strobe = 1'b1;
  logic [2:0]  cfg_isize = '0;
  logic [1:0]  cfg_pack = '0, cfg_clr_sel = '0;
  logic [31:0] out_word;
  logic        out_ready, out_valid, out_overrun;

  always #2 clk = ~clk;

  pcap_packer uut (
    .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .den_a(den_a), .den_b(den_b),
    .cfg_en(cfg_en), .cfg_isize(cfg_isize), .cfg_half(cfg_half), .cfg_first(cfg_first),
    .cfg_always(cfg_always), .cfg_scale(cfg_scale), .cfg_pack(cfg_pack),
    .cfg_clr_sel(cfg_clr_sel), .rd_strobe(rd_strobe), .out_word(out_word),
    .out_ready(out_ready), .out_valid(out_valid), .out_overrun(out_overrun)
  );

  typedef struct { logic [31:0] w; string tag; } exp_t;
  exp_t  expq[$];
  int    checks = 0, errors = 0;
  string tag = "R1";
  bit    done_flag = 0;

  // Reference state built from the requirements
  logic       m_phase = 0, m_pa = 0, m_pb = 0;
  int         m_pos = 0;
  logic [31:0] m_acc = 0;

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic step(input logic [13:0] d, input logic a, input logic b);
    int w, cnt, lw;
    logic clr, cand, kp;
    logic [15:0] v;
    @(negedge clk);
    pix_data = d; den_a = a; den_b = b;
    w = (cfg_isize == 1) ? 10 : (cfg_isize == 2) ? 12 : (cfg_isize == 3) ? 14 : 8;
    cnt = (cfg_pack == 1) ? 2 : (cfg_pack == 2 && w == 8) ? 4 : 1;
    lw = (w == 8) ? 8 : 16;
    case (cfg_clr_sel)
      2'd1: clr = m_pa & ~a;
      2'd2: clr = m_pb & ~b;
      2'd3: clr = (m_pa & ~a) | (m_pb & ~b);
      default: clr = 0;
    endcase
    if (clr || !cfg_en) begin m_phase = 0; m_pos = 0; end
    cand = cfg_en && (cfg_always || (a && b));
    kp = 0;
    if (cand) begin
      kp = !cfg_half || (m_phase == cfg_first);
      m_phase = ~m_phase;
    end
    if (kp) begin
      v = 16'({2'b00, d} & ((32'h1 << w) - 1));
      if (w != 8 && cfg_scale) v = v << (16 - w);
      if (m_pos == 0) m_acc = 0;
      m_acc = m_acc | (32'(v) << (m_pos * lw));
      m_pos++;
    end
    m_pa = a; m_pb = b;
    @(posedge clk); #1;
    if (kp && m_pos == cnt) begin
      expq.push_back('{m_acc, tag});
      m_pos = 0;
    end
  endtask

  task automatic restart_cycle();
    cfg_en = 0; step(0, 0, 0);
    chk("R9 no valid while disabled", 32'(out_valid), 0);
    cfg_en = 1;
  endtask

  // Monitor: compare every completed word against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && !done_flag) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected word actual %h expected none", tag, out_word);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (out_word !== e.w) begin
          errors++;
          $display("FAIL %s: word actual %h expected %h", e.tag, out_word, e.w);
        end
      end
    end
  end

  task automatic finish_run();
    done_flag = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset word", out_word, 0);
    chk("R10 reset flags", {29'b0, out_ready, out_valid, out_overrun}, 0);
    rst_n = 1;
    cfg_en = 1;

    // R1 / R5: 8-bit, one per word, upper bits ignored
    tag = "R1";
    step(14'h3A5, 1, 1); step(14'h05C, 1, 1); step(14'h2FF, 1, 1);
    // R2: one enable alone gives no candidate
    tag = "R2";
    step(14'h011, 1, 0);
    chk("R2 single enable ignored", 32'(out_valid), 0);
    step(14'h022, 0, 1);
    chk("R2 single enable ignored", 32'(out_valid), 0);
    step(14'h033, 1, 1);
    // R3: always sampling, two per word, enables low
    tag = "R3"; cfg_always = 1; cfg_pack = 1; restart_cycle();
    step(14'h0A1, 0, 0); step(14'h0B2, 0, 0); step(14'h0C3, 1, 0); step(14'h0D4, 0, 0);
    // R5: four per word at 8 bits
    tag = "R5"; cfg_pack = 2; restart_cycle();
    for (int i = 0; i < 8; i++) step(14'(8'h10 + i * 17), 0, 0);
    // R4: half sampling, even then odd, with always on and off
    tag = "R4"; cfg_pack = 0; cfg_half = 1; cfg_first = 0; restart_cycle();
    for (int i = 0; i < 6; i++) step(14'(i + 1), 0, 0);
    cfg_first = 1; restart_cycle();
    for (int i = 0; i < 6; i++) step(14'(i + 8'h40), 0, 0);
    cfg_always = 0; restart_cycle();
    for (int i = 0; i < 6; i++) step(14'(i + 8'h70), 1, 1);
    cfg_half = 0;
    // R7: widths and scaling
    tag = "R7"; cfg_pack = 1; cfg_isize = 2; restart_cycle();
    step(14'h3ABC, 1, 1); step(14'h0123, 1, 1);
    cfg_scale = 1; restart_cycle();
    step(14'h0ABC, 1, 1); step(14'h0123, 1, 1);
    cfg_isize = 3; restart_cycle();
    step(14'h3FFF, 1, 1); step(14'h0001, 1, 1);
    cfg_isize = 1; restart_cycle();
    step(14'h03FF, 1, 1); step(14'h0155, 1, 1);
    cfg_isize = 0; cfg_pack = 0; restart_cycle();
    step(14'h00C7, 1, 1);
    cfg_scale = 0;
    // R6: four-pack at 12 bits and reserved code pack one
    tag = "R6"; cfg_isize = 2; cfg_pack = 2; restart_cycle();
    step(14'h0F0F, 1, 1); step(14'h0777, 1, 1);
    cfg_isize = 0; cfg_pack = 3; restart_cycle();
    step(14'h0099, 1, 1); step(14'h0088, 1, 1);
    // R8: restart sources
    tag = "R8"; cfg_pack = 2;
    for (int s = 0; s < 4; s++) begin
      cfg_clr_sel = 2'(s); restart_cycle();
      step(14'h0E1, 1, 1); step(14'h0E2, 1, 1);
      if (s == 2) step(0, 1, 0); else step(0, 0, 1);
      chk("R8 no word on edge", 32'(out_valid), 0);
      step(0, 1, 1);
      for (int i = 0; i < 4; i++) step(14'(8'hF0 + i), 1, 1);
    end
    // R8 with half: a restart returns to index 0
    cfg_pack = 0; cfg_half = 1; cfg_first = 0; cfg_clr_sel = 1; restart_cycle();
    step(14'h055, 1, 1); step(0, 0, 1); step(14'h066, 1, 1); step(14'h077, 1, 1);
    cfg_half = 0; cfg_clr_sel = 0;
    // R9: disabled captures nothing, position restarts
    tag = "R9"; cfg_pack = 1; restart_cycle();
    step(14'h0AA, 1, 1);
    cfg_en = 0;
    for (int i = 0; i < 3; i++) step(14'h0BB, 1, 1);
    chk("R9 no valid while disabled", 32'(out_valid), 0);
    cfg_en = 1;
    step(14'h0CC, 1, 1); step(14'h0DD, 1, 1);
    // R10 / R11: ready, overrun, read
    tag = "R10"; cfg_pack = 0; rd_strobe = 0;
    step(14'h012, 1, 1);
    chk("R10 valid pulse", 32'(out_valid), 1);
    chk("R10 ready set", 32'(out_ready), 1);
    chk("R10 word loaded", out_word, 32'h12);
    step(0, 0, 0);
    chk("R10 valid one cycle", 32'(out_valid), 0);
    chk("R10 ready held", 32'(out_ready), 1);
    tag = "R11";
    step(14'h034, 1, 1);
    chk("R11 overrun set", 32'(out_overrun), 1);
    chk("R11 word replaced", out_word, 32'h34);
    rd_strobe = 1; step(0, 0, 0);
    chk("R10 read clears ready", 32'(out_ready), 0);
    chk("R11 read clears overrun", 32'(out_overrun), 0);
    repeat (3) step(0, 0, 0);
    chk("R5 all words seen", 32'(expq.size()), 0);
    finish_run();
  end

endmodule